// File: doc/BRIEF.md
# Sync-Framed Video to Stream Bridge

This block sits behind a receive-side video port, where timing is carried by vertical sync, horizontal sync and a data-enable strobe. It turns that timing into a stream with valid/ready handshaking, start-of-frame (`m_tuser`) and end-of-line (`m_tlast`) markers. The bridge is clocked faster than the pixel rate, so the data-enable may drop and return several times inside one scan line. Each line is therefore framed by counting accepted pixels against a programmed active width. The end of a line comes from that count, or from the next horizontal sync rising edge.

Each clock can carry one, two or four 48-bit pixel lanes. Inside a lane, three 16-bit slots hold MSB-aligned colour components. The bridge extracts the components named by a runtime format and depth selection and right-justifies them in the output. For 4:2:2 video the single chroma slot alternates between Cr and Cb along the line. The bridge routes the chroma into the Cr or Cb output field accordingly.

The datapath is cleared at the trailing edge of every vertical sync pulse. Any framing error is therefore gone by the next frame. The video port cannot be stalled, so back-pressure that would lose a beat is reported rather than absorbed.

Top module: `vid_stream_bridge`

## Requirements
- R1: A beat is accepted only in a cycle with `vid_de` high. Gaps in `vid_de` inside a line neither drop pixels nor end the line: every accepted beat appears once on the output, in order, and `m_tlast` is not set by a gap.
- R2: `line_cnt` increases by one on each rising edge of `vid_hsync`, however long hsync stays high. It returns to 0 at the vertical sync trailing edge.
- R3: In the cycle after a `vid_vsync` high-to-low transition, the following are all cleared: `line_cnt`, the pixel count, the pending beat, the output beat (`m_tvalid` low), `err_short` and `err_ovf`. The start-of-frame marker is re-armed.
- R4: `cfg_ppc` selects the pixels per beat: 0 gives 1 pixel, 1 gives 2 pixels, 2 gives 4 pixels and 3 gives 1 pixel. `m_tkeep` bit k is set for every used lane. Lanes above the used count are output as zero, whatever is on their inputs.
- R5: Input lane k occupies `vid_pix[48k+47:48k]` and has three slots: [47:32], [31:16] and [15:0]. `cfg_bpc` selects the component depth n: 0 gives 6, 1 gives 8, 2 gives 10, 3 gives 12 and 4 or above gives 16. A component is the top n bits of its slot. It is output right-justified in a 16-bit field: field 0 at [15:0], field 1 at [31:16] and field 2 at [47:32] of the output lane.
- R6: `cfg_fmt` 0 (RGB) and 1 (YCbCr 4:4:4) map slot [47:32] to field 0, slot [31:16] to field 1 and slot [15:0] to field 2. `cfg_fmt` 3 (luma only) maps slot [47:32] to field 0 and zeroes fields 1 and 2.
- R7: In `cfg_fmt` 2 (4:2:2), luma comes from slot [31:16] and goes to field 0. Chroma comes from slot [47:32]. Cr goes to field 2 and Cb to field 1, and the unused chroma field is zero. Chroma alternates per pixel in lane order: the first pixel of every line is Cr.
- R8: `m_tuser` is set on the first beat accepted after a vertical sync trailing edge, and on no later beat of that frame.
- R9: `m_tlast` is set on the beat whose accepted pixel count reaches `cfg_width`, and the pixel count then restarts. A beat is held one stage until its line position is known. It is emitted when the next beat is accepted, when hsync rises, or one cycle later if it ends the line.
- R10: If hsync rises while the pending beat has not reached `cfg_width`, that beat is emitted with `m_tlast` set. `err_short` is then set and stays set until the next vertical sync trailing edge.
- R11: While `m_tvalid` is high and `m_tready` is low, `m_tdata`, `m_tkeep`, `m_tuser` and `m_tlast` hold. A beat that would replace the held beat is dropped, and `err_ovf` is set and stays set until the next vertical sync trailing edge.
- R12: After reset, `m_tvalid`, `line_cnt`, `err_short` and `err_ovf` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_vsync | input | 1 | Vertical sync; trailing edge resets framing |
| vid_hsync | input | 1 | Horizontal sync; rising edge advances the line |
| vid_de | input | 1 | Data enable; a beat is accepted when high |
| vid_pix | input | LANES*48 | Pixel lanes, lane k at [48k+47:48k] |
| cfg_fmt | input | 2 | Colour format: 0 RGB, 1 4:4:4, 2 4:2:2, 3 luma only |
| cfg_bpc | input | 3 | Component depth code |
| cfg_ppc | input | 2 | Pixels-per-beat code |
| cfg_width | input | WIDTH_W | Active pixels per line |
| m_tready | input | 1 | Stream sink ready |
| m_tvalid | output | 1 | Stream beat valid |
| m_tdata | output | LANES*48 | Unpacked pixels, three right-justified 16-bit fields per lane |
| m_tkeep | output | LANES | One bit per used pixel lane |
| m_tuser | output | 1 | Start of frame |
| m_tlast | output | 1 | End of line |
| line_cnt | output | LINE_W | Lines started since the last vertical sync |
| err_short | output | 1 | Sticky: a line ended before its programmed width |
| err_ovf | output | 1 | Sticky: a beat was lost to back-pressure |

## Verification
The bench breaks `vid_de` into bursts inside a line. A design that ended lines on a deasserted enable, or counted idle cycles, would mark `m_tlast` too early or lose beats. The bench holds hsync high for several cycles, which a level-counting design would count as several lines. It ends a line early with hsync, where a design without the holding stage could not attach `m_tlast` to a beat already sent. It checks 4:2:2 chroma on a second line and across two lanes, which exposes a design that does not restart the Cr/Cb phase per line. Vertical sync is dropped mid-line, and stalls are placed on the output so that a stale count or a silently replaced beat shows up.

// File: rtl/vsb_pkg.sv
package vsb_pkg;

    localparam int SLOT_W = 16;
    localparam int PIX_W  = 3 * SLOT_W;

    typedef enum logic [1:0] {
        FMT_RGB   = 2'd0,
        FMT_YC444 = 2'd1,
        FMT_YC422 = 2'd2,
        FMT_LUMA  = 2'd3
    } fmt_e;

    // depth code -> component bit count
    function automatic logic [4:0] comp_bits(input logic [2:0] code);
        case (code)
            3'd0:    comp_bits = 5'd6;
            3'd1:    comp_bits = 5'd8;
            3'd2:    comp_bits = 5'd10;
            3'd3:    comp_bits = 5'd12;
            default: comp_bits = 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/vsb_lane_unpack.sv
module vsb_lane_unpack
    import vsb_pkg::*;
(
    input  logic [PIX_W-1:0] lane_in,
    input  logic [1:0]       fmt,
    input  logic [2:0]       bpc,
    input  logic             is_cr,
    input  logic             en,
    output logic [PIX_W-1:0] pix_out
);

    logic [4:0]        shamt;
    logic [SLOT_W-1:0] top_c;
    logic [SLOT_W-1:0] mid_c;
    logic [SLOT_W-1:0] low_c;

    always_comb begin
        shamt = 5'(SLOT_W) - comp_bits(bpc);
        top_c = lane_in[PIX_W-1 -: SLOT_W] >> shamt;
        mid_c = lane_in[2*SLOT_W-1 -: SLOT_W] >> shamt;
        low_c = lane_in[SLOT_W-1:0] >> shamt;
        pix_out = '0;
        if (en) begin
            case (fmt_e'(fmt))
                FMT_RGB, FMT_YC444: pix_out = {low_c, mid_c, top_c};
                FMT_YC422: pix_out = is_cr ? {top_c, {SLOT_W{1'b0}}, mid_c}
                                           : {{SLOT_W{1'b0}}, top_c, mid_c};
                default:   pix_out = {{2*SLOT_W{1'b0}}, top_c};
            endcase
        end
    end

endmodule

// File: rtl/vsb_sync_edges.sv
module vsb_sync_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync,
    input  logic vsync,
    output logic hs_rise,
    output logic vs_fall
);

    typedef struct packed {
        logic hs;
        logic vs;
    } sync_t;

    sync_t sync_d;
    sync_t sync_q;

    always_comb begin
        sync_d.hs = hsync;
        sync_d.vs = vsync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign hs_rise = hsync & ~sync_q.hs;
    assign vs_fall = sync_q.vs & ~vsync;

endmodule

// File: rtl/vid_stream_bridge.sv
module vid_stream_bridge
    import vsb_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int WIDTH_W = 16,
    parameter int LINE_W  = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vid_vsync,
    input  logic                     vid_hsync,
    input  logic                     vid_de,
    input  logic [LANES*PIX_W-1:0]   vid_pix,
    input  logic [1:0]               cfg_fmt,
    input  logic [2:0]               cfg_bpc,
    input  logic [1:0]               cfg_ppc,
    input  logic [WIDTH_W-1:0]       cfg_width,
    input  logic                     m_tready,
    output logic                     m_tvalid,
    output logic [LANES*PIX_W-1:0]   m_tdata,
    output logic [LANES-1:0]         m_tkeep,
    output logic                     m_tuser,
    output logic                     m_tlast,
    output logic [LINE_W-1:0]        line_cnt,
    output logic                     err_short,
    output logic                     err_ovf
);

    localparam int DW  = LANES * PIX_W;
    localparam int NPW = $clog2(LANES + 1) + 1;

    typedef struct packed {
        logic               pend_v;
        logic               pend_last;
        logic               pend_user;
        logic [LANES-1:0]   pend_keep;
        logic [DW-1:0]      pend_data;
        logic               out_v;
        logic               out_last;
        logic               out_user;
        logic [LANES-1:0]   out_keep;
        logic [DW-1:0]      out_data;
        logic [WIDTH_W-1:0] cnt;
        logic [LINE_W-1:0]  line;
        logic               par;
        logic               sof;
        logic               err_short;
        logic               err_ovf;
    } st_t;

    st_t st_d;
    st_t st_q;

    logic             hs_rise;
    logic             vs_fall;
    logic [NPW-1:0]   npix;
    logic             par_base;
    logic [LANES-1:0] lane_en;
    logic [LANES-1:0] lane_cr;
    logic [DW-1:0]    unpacked;

    vsb_sync_edges u_edges (
        .clk     (clk),
        .rst_n   (rst_n),
        .hsync   (vid_hsync),
        .vsync   (vid_vsync),
        .hs_rise (hs_rise),
        .vs_fall (vs_fall)
    );

    always_comb begin
        case (cfg_ppc)
            2'd1:    npix = (LANES < 2) ? NPW'(LANES) : NPW'(2);
            2'd2:    npix = (LANES < 4) ? NPW'(LANES) : NPW'(4);
            default: npix = NPW'(1);
        endcase
        par_base = hs_rise ? 1'b0 : st_q.par;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_en[k] = (NPW'(k) < npix);
        assign lane_cr[k] = (k % 2 == 0) ? ~par_base : par_base;

        vsb_lane_unpack u_unpack (
            .lane_in (vid_pix[k*PIX_W +: PIX_W]),
            .fmt     (cfg_fmt),
            .bpc     (cfg_bpc),
            .is_cr   (lane_cr[k]),
            .en      (lane_en[k]),
            .pix_out (unpacked[k*PIX_W +: PIX_W])
        );
    end

    logic               flush;
    logic [WIDTH_W-1:0] cnt_base;
    logic [WIDTH_W:0]   tot;
    logic               hit_width;

    always_comb begin
        st_d      = st_q;
        cnt_base  = hs_rise ? '0 : st_q.cnt;
        tot       = {1'b0, cnt_base} + (WIDTH_W+1)'(npix);
        hit_width = (tot >= {1'b0, cfg_width});
        flush     = st_q.pend_v & (vid_de | hs_rise | st_q.pend_last);

        if (st_q.out_v && m_tready) st_d.out_v = 1'b0;

        if (flush) begin
            st_d.pend_v = 1'b0;
            if (st_q.out_v && !m_tready) begin
                st_d.err_ovf = 1'b1;
            end else begin
                st_d.out_v    = 1'b1;
                st_d.out_data = st_q.pend_data;
                st_d.out_keep = st_q.pend_keep;
                st_d.out_user = st_q.pend_user;
                st_d.out_last = st_q.pend_last | hs_rise;
            end
        end

        if (hs_rise) begin
            st_d.line = st_q.line + 1'b1;
            st_d.cnt  = '0;
            st_d.par  = 1'b0;
            if (st_q.pend_v && !st_q.pend_last) st_d.err_short = 1'b1;
        end

        if (vid_de) begin
            st_d.pend_v    = 1'b1;
            st_d.pend_data = unpacked;
            st_d.pend_keep = lane_en;
            st_d.pend_user = st_q.sof;
            st_d.pend_last = hit_width;
            st_d.sof       = 1'b0;
            st_d.cnt       = hit_width ? '0 : tot[WIDTH_W-1:0];
            st_d.par       = hit_width ? 1'b0 : (par_base ^ (npix == NPW'(1)));
        end

        if (vs_fall) begin
            st_d.pend_v    = 1'b0;
            st_d.out_v     = 1'b0;
            st_d.cnt       = '0;
            st_d.line      = '0;
            st_d.par       = 1'b0;
            st_d.sof       = 1'b1;
            st_d.err_short = 1'b0;
            st_d.err_ovf   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.sof <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign m_tvalid  = st_q.out_v;
    assign m_tdata   = st_q.out_data;
    assign m_tkeep   = st_q.out_keep;
    assign m_tuser   = st_q.out_user;
    assign m_tlast   = st_q.out_last;
    assign line_cnt  = st_q.line;
    assign err_short = st_q.err_short;
    assign err_ovf   = st_q.err_ovf;

    a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tready && !vs_fall |=>
            m_tvalid && $stable(m_tdata) && $stable(m_tlast) && $stable(m_tuser));

    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_ovf && !vs_fall |=> err_ovf);

    a_r2_line_step: assert property (@(posedge clk) disable iff (!rst_n)
        hs_rise && !vs_fall |=> line_cnt == LINE_W'($past(line_cnt) + 1'b1));

    a_r3_frame_clear: assert property (@(posedge clk) disable iff (!rst_n)
        vs_fall |=> !m_tvalid && line_cnt == '0 && !err_short && !err_ovf);

    a_r4_keep_shape: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> m_tkeep[0] && ((m_tkeep & LANES'(m_tkeep + 1'b1)) == '0));

    a_r10_short_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_short && !vs_fall |=> err_short);

endmodule

// File: tb/vid_stream_bridge_bench.sv
module vid_stream_bridge_bench;

    localparam int DW = 192;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          vid_vsync, vid_hsync, vid_de;
    logic [DW-1:0] vid_pix;
    logic [1:0]    cfg_fmt;
    logic [2:0]    cfg_bpc;
    logic [1:0]    cfg_ppc;
    logic [15:0]   cfg_width;
    logic          m_tready;
    logic          m_tvalid, m_tuser, m_tlast, err_short, err_ovf;
    logic [DW-1:0] m_tdata;
    logic [3:0]    m_tkeep;
    logic [11:0]   line_cnt;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] rec_data [0:31];
    logic [3:0]    rec_keep [0:31];
    logic          rec_user [0:31];
    logic          rec_last [0:31];
    int            rec_n = 0;

    always #10 clk = ~clk;

    vid_stream_bridge u_vid_stream_bridge (
        .clk(clk), .rst_n(rst_n), .vid_vsync(vid_vsync), .vid_hsync(vid_hsync),
        .vid_de(vid_de), .vid_pix(vid_pix), .cfg_fmt(cfg_fmt), .cfg_bpc(cfg_bpc),
        .cfg_ppc(cfg_ppc), .cfg_width(cfg_width), .m_tready(m_tready),
        .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tuser(m_tuser),
        .m_tlast(m_tlast), .line_cnt(line_cnt), .err_short(err_short), .err_ovf(err_ovf)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [47:0] mkw(input int i);
        mkw = {16'(16'h8000 + i * 16'h0123), 16'(16'h4321 + i * 16'h0101), 16'(16'hF00F - i * 16'h0011)};
    endfunction

    function automatic logic [47:0] exp_lane(input logic [1:0] f, input logic [2:0] b,
                                             input logic [47:0] w, input bit cr);
        int n;
        logic [15:0] a, g, c;
        case (b)
            3'd0: n = 6;  3'd1: n = 8;  3'd2: n = 10;  3'd3: n = 12;
            default: n = 16;
        endcase
        a = w[47:32] >> (16 - n);
        g = w[31:16] >> (16 - n);
        c = w[15:0]  >> (16 - n);
        case (f)
            2'd0, 2'd1: exp_lane = {c, g, a};
            2'd2:       exp_lane = cr ? {a, 16'h0, g} : {16'h0, a, g};
            default:    exp_lane = {32'h0, a};
        endcase
    endfunction

    function automatic logic [DW-1:0] exp_beat(input int np, input logic [DW-1:0] pix, input int par0);
        exp_beat = '0;
        for (int k = 0; k < 4; k++)
            if (k < np)
                exp_beat[k*48 +: 48] = exp_lane(cfg_fmt, cfg_bpc, pix[k*48 +: 48], ((par0 + k) % 2) == 0);
    endfunction

    function automatic logic [DW-1:0] one_lane(input int i);
        one_lane = {{144{1'b1}}, mkw(i)};
    endfunction

    function automatic logic [DW-1:0] all_lanes(input int i);
        all_lanes = {mkw(i + 3), mkw(i + 2), mkw(i + 1), mkw(i)};
    endfunction

    task automatic cyc(input logic vs, input logic hs, input logic de, input logic [DW-1:0] pix);
        vid_vsync = vs; vid_hsync = hs; vid_de = de; vid_pix = pix;
        if (m_tvalid && m_tready && rec_n < 32) begin
            rec_data[rec_n] = m_tdata; rec_keep[rec_n] = m_tkeep;
            rec_user[rec_n] = m_tuser; rec_last[rec_n] = m_tlast;
            rec_n++;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) cyc(1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic frame_start();
        cyc(1'b1, 1'b0, 1'b0, '0);
        cyc(1'b1, 1'b0, 1'b0, '0);
        cyc(1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic line_start();
        cyc(1'b0, 1'b1, 1'b0, '0);
        cyc(1'b0, 1'b1, 1'b0, '0);
        cyc(1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic t_reset_state();
        check("R12 tvalid after reset", DW'(m_tvalid), '0);
        check("R12 line_cnt after reset", DW'(line_cnt), '0);
        check("R12 error flags after reset", DW'({err_short, err_ovf}), '0);
    endtask

    task automatic t_gapped_line();
        cfg_fmt = 2'd0; cfg_bpc = 3'd1; cfg_ppc = 2'd0; cfg_width = 16'd4;
        frame_start(); line_start(); rec_n = 0;
        cyc(1'b0, 1'b0, 1'b1, one_lane(0)); idle(1);
        cyc(1'b0, 1'b0, 1'b1, one_lane(1)); idle(2);
        cyc(1'b0, 1'b0, 1'b1, one_lane(2));
        cyc(1'b0, 1'b0, 1'b1, one_lane(3)); idle(3);
        check("R1 beat count with de gaps", DW'(rec_n), DW'(4));
        for (int i = 0; i < 4; i++) begin
            check("R5 R6 rgb 8-bit data, disabled lanes zero (R4)", rec_data[i], exp_beat(1, one_lane(i), 0));
            check("R8 tuser only on first beat", DW'(rec_user[i]), DW'(i == 0));
            check("R9 tlast only at width", DW'(rec_last[i]), DW'(i == 3));
            check("R4 keep single lane", DW'(rec_keep[i]), DW'(4'b0001));
        end
        check("R2 line count after one hsync", DW'(line_cnt), DW'(1));
    endtask

    task automatic t_depths();
        cfg_fmt = 2'd1; cfg_width = 16'd1; cfg_ppc = 2'd0;
        for (int b = 0; b < 5; b++) begin
            cfg_bpc = 3'(b); rec_n = 0;
            cyc(1'b0, 1'b0, 1'b1, one_lane(b + 5)); idle(3);
            check("R5 depth sweep 4:4:4", rec_data[0], exp_beat(1, one_lane(b + 5), 0));
        end
        cfg_fmt = 2'd3; cfg_bpc = 3'd2; rec_n = 0;
        cyc(1'b0, 1'b0, 1'b1, one_lane(9)); idle(3);
        check("R6 luma only 10-bit", rec_data[0], exp_beat(1, one_lane(9), 0));
    endtask

    task automatic t_chroma();
        cfg_fmt = 2'd2; cfg_bpc = 3'd1; cfg_ppc = 2'd0; cfg_width = 16'd4;
        frame_start(); line_start(); rec_n = 0;
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b1, one_lane(i));
        idle(3);
        line_start();
        cyc(1'b0, 1'b0, 1'b1, one_lane(7));
        cyc(1'b0, 1'b0, 1'b1, one_lane(8));
        line_start(); idle(2);
        for (int i = 0; i < 4; i++)
            check("R7 4:2:2 Cr/Cb alternation", rec_data[i], exp_beat(1, one_lane(i), i % 2));
        check("R7 Cr restarts on new line", rec_data[4], exp_beat(1, one_lane(7), 0));
        check("R7 second pixel Cb", rec_data[5], exp_beat(1, one_lane(8), 1));
        frame_start();
        cfg_ppc = 2'd1; cfg_width = 16'd2; line_start(); rec_n = 0;
        cyc(1'b0, 1'b0, 1'b1, all_lanes(2)); idle(3);
        check("R7 two-lane Cr then Cb, upper lanes zero", rec_data[0], exp_beat(2, all_lanes(2), 0));
        check("R4 keep two lanes", DW'(rec_keep[0]), DW'(4'b0011));
    endtask

    task automatic t_quad();
        cfg_fmt = 2'd0; cfg_bpc = 3'd4; cfg_ppc = 2'd2; cfg_width = 16'd8;
        frame_start(); line_start(); rec_n = 0;
        cyc(1'b0, 1'b0, 1'b1, all_lanes(0));
        cyc(1'b0, 1'b0, 1'b1, all_lanes(4)); idle(3);
        check("R4 four-lane beats", DW'(rec_n), DW'(2));
        check("R4 keep four lanes", DW'(rec_keep[1]), DW'(4'b1111));
        check("R9 tlast at 8 pixels", DW'({rec_last[0], rec_last[1]}), DW'(2'b01));
        check("R5 16-bit four-lane data", rec_data[1], exp_beat(4, all_lanes(4), 0));
    endtask

    task automatic t_short_line();
        cfg_fmt = 2'd0; cfg_bpc = 3'd1; cfg_ppc = 2'd0; cfg_width = 16'd8;
        frame_start(); line_start(); rec_n = 0;
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b1, one_lane(i));
        idle(1);
        check("R10 no error before hsync", DW'(err_short), '0);
        line_start(); idle(1);
        check("R10 short line beats", DW'(rec_n), DW'(3));
        check("R10 tlast on last accepted beat", DW'({rec_last[1], rec_last[2]}), DW'(2'b01));
        check("R10 short flag set", DW'(err_short), DW'(1));
        idle(2);
        check("R10 short flag sticky", DW'(err_short), DW'(1));
        frame_start();
        check("R3 short flag cleared by vsync", DW'(err_short), '0);
    endtask

    task automatic t_backpressure();
        cfg_fmt = 2'd0; cfg_bpc = 3'd1; cfg_ppc = 2'd0; cfg_width = 16'd1;
        frame_start(); line_start(); rec_n = 0;
        m_tready = 1'b0;
        cyc(1'b0, 1'b0, 1'b1, one_lane(1)); idle(1);
        cyc(1'b0, 1'b0, 1'b1, one_lane(2)); idle(1);
        check("R11 held data under stall", m_tdata, exp_beat(1, one_lane(1), 0));
        check("R11 overflow flag", DW'(err_ovf), DW'(1));
        m_tready = 1'b1; idle(3);
        check("R11 only held beat delivered", DW'(rec_n), DW'(1));
        check("R11 delivered data", rec_data[0], exp_beat(1, one_lane(1), 0));
        check("R11 overflow sticky", DW'(err_ovf), DW'(1));
        frame_start();
        check("R3 overflow cleared by vsync", DW'(err_ovf), '0);
    endtask

    task automatic t_line_count();
        frame_start();
        check("R3 line count cleared", DW'(line_cnt), '0);
        repeat (5) cyc(1'b0, 1'b1, 1'b0, '0);
        idle(1);
        check("R2 long hsync counts once", DW'(line_cnt), DW'(1));
        line_start(); line_start();
        check("R2 three lines", DW'(line_cnt), DW'(3));
    endtask

    task automatic t_vsync_midline();
        cfg_fmt = 2'd0; cfg_bpc = 3'd1; cfg_ppc = 2'd0; cfg_width = 16'd4;
        frame_start(); line_start(); rec_n = 0;
        cyc(1'b0, 1'b0, 1'b1, one_lane(0));
        cyc(1'b0, 1'b0, 1'b1, one_lane(1));
        frame_start();
        check("R3 output cleared after vsync", DW'(m_tvalid), '0);
        line_start();
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b1, one_lane(i + 4));
        idle(3);
        check("R3 pending beat dropped", DW'(rec_n), DW'(5));
        check("R8 tuser re-armed", DW'(rec_user[1]), DW'(1));
        check("R3 pixel count restarted", DW'({rec_last[3], rec_last[4]}), DW'(2'b01));
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; vid_vsync = 1'b0; vid_hsync = 1'b0; vid_de = 1'b0; vid_pix = '0;
        cfg_fmt = '0; cfg_bpc = 3'd1; cfg_ppc = '0; cfg_width = 16'd4; m_tready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_gapped_line();
        t_depths();
        t_chroma();
        t_quad();
        t_short_line();
        t_backpressure();
        t_line_count();
        t_vsync_midline();
        finish_run();
    end

endmodule